// File: doc/BRIEF.md
# Core Module Control Register Bank

This block is the configuration and status register set of a processor core module. A host reaches it over a simple word-addressed bus with one request per cycle: a write takes effect at the clock edge that accepts it, and a read returns its data, flagged valid, in the cycle after the request.

The bank holds several kinds of state:

- oscillator settings, with a primary and an auxiliary register;
- memory setup words;
- two groups of general-purpose flags;
- a control register that lights an LED, moves the boot flash out of address zero and requests a system reset.

Writes to the oscillator registers are refused unless a 16-bit unlock key has been stored first. The bank also contains:

- a 32-bit reference counter, advanced by an external tick enable;
- a read-only window onto a 128-entry memory-presence byte table;
- a one-bit software interrupt source with separate IRQ and FIQ enable masks.

Word addresses that hold nothing read as zero. A write to an address that accepts no write is dropped and flagged for one cycle on a decode-error output.

Top module: `cm_regbank`

## Requirements
- R1: After reset the registers read as follows: word 0 (oscillator) is 0x01000048, word 7 (auxiliary oscillator) is 0x0007FEFF, word 8 is 0x00011122, word 9 is 0x00000112, and every other register is zero. A read issued in cycle N has its data on bus_rdata_o with bus_rvalid_o high in cycle N+1. bus_rvalid_o is low in any cycle that does not follow a read.
- R2: A write to word 5 stores bits 15:0 of the data as the key. A read of word 5 returns the key in bits 15:0, returns 1 in bit 16 when the key equals 0xA05F, and returns zero in all other bits. Writes to word 0 and word 7 change the register only while the stored key equals 0xA05F.
- R3: A write to word 3 stores data bit 0 as the LED bit and data bit 2 as the remap bit; all other bits are dropped. A read of word 3 returns the LED bit in bit 0, the remap bit in bit 2 and zero elsewhere, so bit 3 always reads zero. led_o follows the LED bit.
- R4: A write to word 3 with data bit 3 set drives reset_req_o high for exactly the one cycle after the write.
- R5: flash_at_zero_o is high while the stored remap bit is 0 and low while it is 1. It is high after reset.
- R6: A write to word 12 ORs the data into the flags register, and a write to word 13 clears the flags bits that are set in the data. Words 14 and 15 do the same for the non-volatile flags register. The flags read at word 12 and the non-volatile flags at word 14.
- R7: Writes to word 8 and word 9 replace the whole 32-bit value, with no key needed.
- R8: Word 10 reads a 32-bit counter that is zero after reset and advances by one in every cycle in which tick_i is high.
- R9: Word addresses 64 to 127 read entry [address] of the 128-entry presence table, zero-extended. Entries 73 to 83 hold the ASCII text "CORE-MODULE", one character per entry in ascending order (entry 73 = 0x43). All other entries are zero.
- R10: Words 18 and 26 set bits of the IRQ and FIQ enable masks, and words 19 and 27 clear them; words 18 and 26 read the masks back. Word 17 and word 25 read the raw level. Word 16 reads the level AND the IRQ mask, and word 24 reads the level AND the FIQ mask.
- R11: A write to word 20 with data bit 0 set raises the level bit 0, and a write to word 21 with data bit 0 set clears it. Other data bits of these writes have no effect. Word 20 reads the level. irq_o is the OR of (level AND IRQ mask), and fiq_o is the OR of (level AND FIQ mask).
- R12: Reads of word 6, words 32 to 35 and every other unlisted address return zero. A write to an address outside the writable set {0, 3, 5, 7, 8, 9, 12-15, 18-21, 26, 27, 32-35} changes nothing and drives dec_err_o high for the one following cycle. Writes to words 32 to 35 are dropped silently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Request valid this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W (7) | Word address |
| bus_wdata_i | input | DATA_W (32) | Write data |
| tick_i | input | 1 | Reference counter advance enable |
| bus_rvalid_o | output | 1 | Read data valid |
| bus_rdata_o | output | DATA_W (32) | Read data |
| led_o | output | 1 | LED drive |
| flash_at_zero_o | output | 1 | Boot flash mapped at address zero |
| reset_req_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | Local interrupt, IRQ path |
| fiq_o | output | 1 | Local interrupt, FIQ path |
| dec_err_o | output | 1 | One-cycle flag for a dropped write |

## Verification
The oscillator registers are written both with a wrong key and with the right key, and again after the key is withdrawn. This separates key gating from plain storage. The set and clear addresses of each flag group get overlapping bit patterns, so an OR, a mask-clear and an overwrite produce different values, and the two groups are checked for independence. The interrupt source is driven through every combination of level with the IRQ and FIQ masks, and the software-set write is also tried with bit 0 clear. Writes to read-only and unmapped addresses are followed by reads of the state they could have touched.

// File: rtl/cm_pkg.sv
package cm_pkg;
    // word addresses whose decode sets behaviour
    localparam logic [31:0] W_OSC      = 32'd0;
    localparam logic [31:0] W_CTRL     = 32'd3;
    localparam logic [31:0] W_LOCK     = 32'd5;
    localparam logic [31:0] W_AUX      = 32'd7;
    localparam logic [31:0] W_SDRAM    = 32'd8;
    localparam logic [31:0] W_INIT     = 32'd9;
    localparam logic [31:0] W_REFCNT   = 32'd10;
    localparam logic [31:0] W_FLG_SET  = 32'd12;
    localparam logic [31:0] W_FLG_CLR  = 32'd13;
    localparam logic [31:0] W_NVF_SET  = 32'd14;
    localparam logic [31:0] W_NVF_CLR  = 32'd15;
    localparam logic [31:0] W_ISTAT    = 32'd16;
    localparam logic [31:0] W_IRAW     = 32'd17;
    localparam logic [31:0] W_IEN_SET  = 32'd18;
    localparam logic [31:0] W_IEN_CLR  = 32'd19;
    localparam logic [31:0] W_SOFT_SET = 32'd20;
    localparam logic [31:0] W_SOFT_CLR = 32'd21;
    localparam logic [31:0] W_FSTAT    = 32'd24;
    localparam logic [31:0] W_FRAW     = 32'd25;
    localparam logic [31:0] W_FEN_SET  = 32'd26;
    localparam logic [31:0] W_FEN_CLR  = 32'd27;
    localparam logic [31:0] W_VOLT_LO  = 32'd32;
    localparam logic [31:0] W_VOLT_HI  = 32'd35;

    localparam logic [15:0] UNLOCK_KEY = 16'hA05F;

    localparam logic [31:0] RST_OSC   = 32'h0100_0048;
    localparam logic [31:0] RST_AUX   = 32'h0007_FEFF;
    localparam logic [31:0] RST_SDRAM = 32'h0001_1122;
    localparam logic [31:0] RST_INIT  = 32'h0000_0112;

    // identification text stored in the presence table
    localparam int          ID_BASE = 73;
    localparam int          ID_LEN  = 11;
    localparam logic [87:0] ID_TEXT = "CORE-MODULE";

    function automatic logic [7:0] presence_byte(input int idx);
        if (idx >= ID_BASE && idx < ID_BASE + ID_LEN)
            return ID_TEXT[8*(ID_LEN-1-(idx-ID_BASE)) +: 8];
        return 8'h00;
    endfunction
endpackage

// File: rtl/cm_refcount.sv
module cm_refcount #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    output logic [CNT_W-1:0] count_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (tick_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/cm_intc.sv
module cm_intc #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              ien_set_i,
    input  logic              ien_clr_i,
    input  logic              fen_set_i,
    input  logic              fen_clr_i,
    input  logic              soft_set_i,
    input  logic              soft_clr_i,
    output logic [DATA_W-1:0] level_o,
    output logic [DATA_W-1:0] ien_o,
    output logic [DATA_W-1:0] fen_o,
    output logic              irq_o,
    output logic              fiq_o
);
    typedef struct packed {
        logic              lvl;
        logic [DATA_W-1:0] ien;
        logic [DATA_W-1:0] fen;
    } ic_t;

    ic_t ic_d, ic_q;

    always_comb begin
        ic_d = ic_q;
        if (ien_set_i)  ic_d.ien = ic_q.ien | wdata_i;
        if (ien_clr_i)  ic_d.ien = ic_q.ien & ~wdata_i;
        if (fen_set_i)  ic_d.fen = ic_q.fen | wdata_i;
        if (fen_clr_i)  ic_d.fen = ic_q.fen & ~wdata_i;
        if (soft_set_i && wdata_i[0]) ic_d.lvl = 1'b1;
        if (soft_clr_i && wdata_i[0]) ic_d.lvl = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ic_q <= '0;
        else        ic_q <= ic_d;
    end

    assign level_o = {{(DATA_W-1){1'b0}}, ic_q.lvl};
    assign ien_o   = ic_q.ien;
    assign fen_o   = ic_q.fen;
    assign irq_o   = |(level_o & ic_q.ien);
    assign fiq_o   = |(level_o & ic_q.fen);
endmodule

// File: rtl/cm_presence.sv
module cm_presence #(
    parameter int DEPTH = 128,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [7:0]       byte_o
);
    logic [7:0] tbl [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
        assign tbl[gi] = cm_pkg::presence_byte(gi);
    end

    assign byte_o = tbl[idx_i];
endmodule

// File: rtl/cm_regbank.sv
module cm_regbank #(
    parameter int ADDR_W    = 7,
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 32,
    parameter int TBL_DEPTH = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic              tick_i,
    output logic              bus_rvalid_o,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              led_o,
    output logic              flash_at_zero_o,
    output logic              reset_req_o,
    output logic              irq_o,
    output logic              fiq_o,
    output logic              dec_err_o
);
    import cm_pkg::*;

    localparam int          TIDX_W = $clog2(TBL_DEPTH);
    localparam logic [31:0] WIN_LO = 32'(TBL_DEPTH / 2);
    localparam logic [31:0] WIN_HI = 32'(TBL_DEPTH - 1);

    typedef struct packed {
        logic [DATA_W-1:0] osc;
        logic [DATA_W-1:0] aux;
        logic [DATA_W-1:0] sdram;
        logic [DATA_W-1:0] init;
        logic [DATA_W-1:0] flags;
        logic [DATA_W-1:0] nvflags;
        logic [15:0]       key;
        logic              led;
        logic              remap;
        logic              rst_req;
        logic              dec_err;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } st_t;

    st_t st_d, st_q;

    logic [31:0]       widx;
    logic              wr_hit, rd_hit, unlocked;
    logic [DATA_W-1:0] rd_mux;
    logic [CNT_W-1:0]  refcnt;
    logic [7:0]        tbl_byte;
    logic [DATA_W-1:0] lvl, ien, fen;

    assign widx     = 32'(bus_addr_i);
    assign wr_hit   = bus_sel_i && bus_wr_i;
    assign rd_hit   = bus_sel_i && !bus_wr_i;
    assign unlocked = (st_q.key == UNLOCK_KEY);

    cm_refcount #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .count_o(refcnt)
    );

    cm_presence #(.DEPTH(TBL_DEPTH), .IDX_W(TIDX_W)) u_tbl (
        .idx_i(bus_addr_i[TIDX_W-1:0]), .byte_o(tbl_byte)
    );

    cm_intc #(.DATA_W(DATA_W)) u_intc (
        .clk(clk), .rst_n(rst_n), .wdata_i(bus_wdata_i),
        .ien_set_i (wr_hit && widx == W_IEN_SET),
        .ien_clr_i (wr_hit && widx == W_IEN_CLR),
        .fen_set_i (wr_hit && widx == W_FEN_SET),
        .fen_clr_i (wr_hit && widx == W_FEN_CLR),
        .soft_set_i(wr_hit && widx == W_SOFT_SET),
        .soft_clr_i(wr_hit && widx == W_SOFT_CLR),
        .level_o(lvl), .ien_o(ien), .fen_o(fen),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    // read data selection
    always_comb begin
        rd_mux = '0;
        if (widx >= WIN_LO && widx <= WIN_HI) begin
            rd_mux = DATA_W'(tbl_byte);
        end else begin
            case (widx)
                W_OSC:      rd_mux = st_q.osc;
                W_CTRL:     rd_mux = DATA_W'({st_q.remap, 1'b0, st_q.led});
                W_LOCK:     rd_mux = DATA_W'({unlocked, st_q.key});
                W_AUX:      rd_mux = st_q.aux;
                W_SDRAM:    rd_mux = st_q.sdram;
                W_INIT:     rd_mux = st_q.init;
                W_REFCNT:   rd_mux = DATA_W'(refcnt);
                W_FLG_SET:  rd_mux = st_q.flags;
                W_NVF_SET:  rd_mux = st_q.nvflags;
                W_ISTAT:    rd_mux = lvl & ien;
                W_IRAW:     rd_mux = lvl;
                W_IEN_SET:  rd_mux = ien;
                W_SOFT_SET: rd_mux = lvl;
                W_FSTAT:    rd_mux = lvl & fen;
                W_FRAW:     rd_mux = lvl;
                W_FEN_SET:  rd_mux = fen;
                default:    rd_mux = '0;
            endcase
        end
    end

    // next-state computation
    always_comb begin
        st_d         = st_q;
        st_d.rvalid  = rd_hit;
        st_d.rdata   = rd_hit ? rd_mux : '0;
        st_d.rst_req = 1'b0;
        st_d.dec_err = 1'b0;
        if (wr_hit) begin
            case (widx)
                W_OSC:      if (unlocked) st_d.osc = bus_wdata_i;
                W_AUX:      if (unlocked) st_d.aux = bus_wdata_i;
                W_CTRL: begin
                    st_d.led     = bus_wdata_i[0];
                    st_d.remap   = bus_wdata_i[2];
                    st_d.rst_req = bus_wdata_i[3];
                end
                W_LOCK:     st_d.key     = bus_wdata_i[15:0];
                W_SDRAM:    st_d.sdram   = bus_wdata_i;
                W_INIT:     st_d.init    = bus_wdata_i;
                W_FLG_SET:  st_d.flags   = st_q.flags | bus_wdata_i;
                W_FLG_CLR:  st_d.flags   = st_q.flags & ~bus_wdata_i;
                W_NVF_SET:  st_d.nvflags = st_q.nvflags | bus_wdata_i;
                W_NVF_CLR:  st_d.nvflags = st_q.nvflags & ~bus_wdata_i;
                W_IEN_SET, W_IEN_CLR, W_FEN_SET, W_FEN_CLR,
                W_SOFT_SET, W_SOFT_CLR: ;
                default: begin
                    if (!(widx >= W_VOLT_LO && widx <= W_VOLT_HI))
                        st_d.dec_err = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.osc   <= RST_OSC;
            st_q.aux   <= RST_AUX;
            st_q.sdram <= RST_SDRAM;
            st_q.init  <= RST_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rvalid_o    = st_q.rvalid;
    assign bus_rdata_o     = st_q.rdata;
    assign led_o           = st_q.led;
    assign flash_at_zero_o = !st_q.remap;
    assign reset_req_o     = st_q.rst_req;
    assign dec_err_o       = st_q.dec_err;
endmodule

// File: rtl/cm_regbank_chk.sv
module cm_regbank_chk #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              rvalid,
    input logic [DATA_W-1:0] rdata,
    input logic              flash,
    input logic              rst_req,
    input logic              irq,
    input logic              fiq,
    input logic              dec_err,
    input logic [15:0]       key,
    input logic [DATA_W-1:0] osc_val
);
    import cm_pkg::*;

    logic [31:0] a;
    assign a = 32'(addr);

    p_rvalid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr) |=> rvalid);
    p_rvalid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && !wr) |=> !rvalid);
    p_osc_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && a == W_OSC && key != UNLOCK_KEY) |=> $stable(osc_val));
    p_ctrl_bit3_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr && a == W_CTRL) |=> !rdata[3]);
    p_rst_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(sel && wr && a == W_CTRL && wdata[3]));
    p_remap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && a == W_CTRL) |=> (flash == !$past(wdata[2])));
    p_softclr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && a == W_SOFT_CLR && wdata[0]) |=> (!irq && !fiq));
    p_decerr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        dec_err |-> $past(sel && wr));
endmodule

bind cm_regbank cm_regbank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel_i), .wr(bus_wr_i),
    .addr(bus_addr_i), .wdata(bus_wdata_i), .rvalid(bus_rvalid_o),
    .rdata(bus_rdata_o), .flash(flash_at_zero_o), .rst_req(reset_req_o),
    .irq(irq_o), .fiq(fiq_o), .dec_err(dec_err_o),
    .key(st_q.key), .osc_val(st_q.osc)
);

// File: tb/cm_regbank_bench.sv
module cm_regbank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wr = 1'b0, tick = 1'b0;
    logic [6:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        rvalid, led, flash, rreq, irq, fiq, derr;
    logic [31:0] rdata;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sbq[$];

    always #5 clk = ~clk;

    cm_regbank u_cm_regbank (
        .clk(clk), .rst_n(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .tick_i(tick),
        .bus_rvalid_o(rvalid), .bus_rdata_o(rdata), .led_o(led),
        .flash_at_zero_o(flash), .reset_req_o(rreq), .irq_o(irq),
        .fiq_o(fiq), .dec_err_o(derr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_w(input int a, input logic [31:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = 7'(a); wdata = d;
    endtask

    task automatic bus_r(input int a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = 7'(a);
        it.exp = e; it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    // monitor: pops expected read data as results appear
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rvalid) begin
                if (sbq.size() == 0) begin
                    chk("R1 unexpected rvalid", 32'd1, 32'd0);
                end else begin
                    item_t it;
                    it = sbq.pop_front();
                    chk(it.tag, rdata, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R1 reset state
        chk("R5 flash at zero after reset", 32'(flash), 32'd1);
        chk("R3 led after reset", 32'(led), 32'd0);
        chk("R11 irq after reset", 32'(irq), 32'd0);
        chk("R4 reset_req after reset", 32'(rreq), 32'd0);
        bus_r(0,  32'h0100_0048, "R1 osc reset");
        bus_r(7,  32'h0007_FEFF, "R1 aux reset");
        bus_r(8,  32'h0001_1122, "R1 sdram reset");
        bus_r(9,  32'h0000_0112, "R1 init reset");
        bus_r(3,  32'h0, "R1 ctrl reset");
        bus_r(12, 32'h0, "R1 flags reset");
        bus_r(10, 32'h0, "R8 counter reset");
        idle();
        // R8 counter ticks
        repeat (5) begin @(negedge clk); tick = 1'b1; end
        @(negedge clk); tick = 1'b0;
        @(negedge clk);
        bus_r(10, 32'd5, "R8 counter after 5 ticks");
        // R2 key gating
        bus_w(0, 32'hDEAD_BEEF);
        bus_r(0, 32'h0100_0048, "R2 osc locked");
        bus_w(5, 32'h1234_A05F);
        bus_r(5, 32'h0001_A05F, "R2 key readback");
        bus_w(0, 32'h1234_5678);
        bus_r(0, 32'h1234_5678, "R2 osc unlocked");
        bus_w(7, 32'h0000_CAFE);
        bus_r(7, 32'h0000_CAFE, "R2 aux unlocked");
        bus_w(5, 32'h0000_A05E);
        bus_r(5, 32'h0000_A05E, "R2 wrong key readback");
        bus_w(7, 32'h1);
        bus_r(7, 32'h0000_CAFE, "R2 aux relocked");
        // R3 R5 control
        bus_w(3, 32'hFFFF_FFF7);
        idle();
        chk("R3 led on", 32'(led), 32'd1);
        chk("R5 flash moved", 32'(flash), 32'd0);
        chk("R4 no reset without bit3", 32'(rreq), 32'd0);
        bus_r(3, 32'h5, "R3 ctrl keeps bits 0 and 2");
        bus_w(3, 32'h8);
        idle();
        chk("R4 reset pulse", 32'(rreq), 32'd1);
        idle();
        chk("R4 reset pulse ends", 32'(rreq), 32'd0);
        chk("R5 flash back at zero", 32'(flash), 32'd1);
        chk("R3 led off", 32'(led), 32'd0);
        bus_r(3, 32'h0, "R3 bit3 reads zero");
        // R6 flags
        bus_w(12, 32'h0000_F0F0);
        bus_w(12, 32'h0000_000F);
        bus_r(12, 32'h0000_F0FF, "R6 flags set ORs");
        bus_w(13, 32'h0000_00F3);
        bus_r(12, 32'h0000_F00C, "R6 flags clear");
        bus_w(14, 32'h0000_00A5);
        bus_w(15, 32'h0000_0005);
        bus_r(14, 32'h0000_00A0, "R6 nvflags set/clear");
        bus_r(12, 32'h0000_F00C, "R6 flags independent");
        bus_r(13, 32'h0, "R12 clear address reads zero");
        // R7
        bus_w(8, 32'h5555_AAAA);
        bus_w(9, 32'h0000_0077);
        bus_r(8, 32'h5555_AAAA, "R7 sdram write");
        bus_r(9, 32'h0000_0077, "R7 init write");
        // R9 table
        bus_r(73, 32'h43, "R9 entry 73");
        bus_r(77, 32'h2D, "R9 entry 77");
        bus_r(83, 32'h45, "R9 entry 83");
        bus_r(64, 32'h0, "R9 entry 64");
        bus_r(127, 32'h0, "R9 entry 127");
        // R10 R11 interrupt
        bus_w(20, 32'h2);
        bus_r(17, 32'h0, "R11 soft set ignores bit1");
        bus_w(18, 32'h3);
        bus_r(18, 32'h3, "R10 irq mask");
        bus_w(20, 32'h1);
        idle();
        chk("R11 irq on", 32'(irq), 32'd1);
        chk("R11 fiq off", 32'(fiq), 32'd0);
        bus_r(16, 32'h1, "R10 irq status");
        bus_r(24, 32'h0, "R10 fiq status masked");
        bus_r(20, 32'h1, "R11 soft readback");
        bus_w(26, 32'h1);
        idle();
        chk("R11 fiq on", 32'(fiq), 32'd1);
        bus_r(24, 32'h1, "R10 fiq status");
        bus_r(26, 32'h1, "R10 fiq mask");
        bus_w(19, 32'h1);
        idle();
        chk("R11 irq masked", 32'(irq), 32'd0);
        bus_r(18, 32'h2, "R10 irq mask clear");
        bus_r(16, 32'h0, "R10 irq status after clear");
        bus_w(21, 32'h1);
        idle();
        chk("R11 fiq after soft clear", 32'(fiq), 32'd0);
        bus_r(25, 32'h0, "R10 raw level cleared");
        // R12 undecoded space
        bus_r(6, 32'h0, "R12 word 6 zero");
        bus_r(33, 32'h0, "R12 voltage zero");
        bus_r(1, 32'h0, "R12 word 1 zero");
        bus_w(17, 32'h1);
        idle();
        chk("R12 dec_err on raw write", 32'(derr), 32'd1);
        bus_r(17, 32'h0, "R12 raw write ignored");
        bus_w(10, 32'hFFFF_0000);
        idle();
        chk("R12 dec_err on counter write", 32'(derr), 32'd1);
        bus_r(10, 32'd5, "R12 counter write ignored");
        bus_w(33, 32'hFFFF_FFFF);
        idle();
        chk("R12 voltage write silent", 32'(derr), 32'd0);
        idle();
        idle();
        chk("R1 scoreboard drained", 32'(sbq.size()), 32'd0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule